// File: doc/BRIEF.md
# Baud Tick Generator with Selectable Prescaler

This block produces the oversampling strobe for one serial channel. A reference clock first passes through a prescaler. Software selects whether the prescaler divides by 1 or by 4. A 16-bit divisor then divides the prescaled rate further. The result is a one-clock strobe, `tick`, at sixteen times the serial bit rate. The transmitter and receiver both count this strobe.

The serial bit rate is the reference frequency divided by (prescale × divisor × 16). With a 14.7456 MHz reference, prescale 1 and divisor 1, the bit rate is 921.6 kbps. With a 50 MHz reference under the same settings, it is 3.125 Mbps, which is the top rate.

Software programs the block through a byte-wide write port. This port has one register for each divisor byte and one control register. Out of reset the block uses divide-by-4 and a divisor of zero, so the strobe stays silent until software loads a divisor. That matches the power-up habit of the classic 16550 generator. Any write to a decoded register restarts the counting, so a new setting never produces a truncated period.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset `tick` is low, the divisor is 0 and the prescaler divides by 4.
- R2: With prescale P and a divisor D that is not zero, `tick` is high in exactly every (P×D)-th clock cycle. P is 1 when control bit 0 is 1 and 4 when it is 0.
- R3: Whenever P×D is greater than 1, `tick` is high for one clock cycle only.
- R4: A divisor of 0 holds `tick` low.
- R5: A write to any decoded register restarts the count. `tick` is low right after the write edge, and the first strobe follows exactly P×D cycles after that edge, whatever phase the count had reached.
- R6: The write address map is as follows: 0 is the divisor low byte, 1 is the divisor high byte, and 2 is control, with bit 0 as the prescale select. A write to address 3 is ignored: it changes no setting and does not disturb the strobe phase.
- R7: With P×D equal to 1, `tick` stays high on every cycle after the write edge.
- R8: Writing one divisor byte leaves the other byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| tick | output | 1 | Oversampling strobe, one cycle wide |

## Verification
Every result is timed from the rising edge that takes a write, called cycle 0. `tick` must be low in cycle 0 and first rises in cycle P×D, because the counter and the output are both registered. The bench samples `tick` on the falling edge of each cycle after that write. It compares cycle k against the arithmetic rule that `tick` is high when k is a nonzero multiple of P×D. It does this for both prescale settings over a sweep of divisors. Restart and ignored-address cases use the same cycle count, taken from the last decoded write.

// File: rtl/baud_pkg.sv
package baud_pkg;

   typedef enum logic {
      PRE_SLOW = 1'b0,
      PRE_FAST = 1'b1
   } pre_mode_e;

   localparam int CTRL_MODE_BIT = 0;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/baud_regs.sv
module baud_regs
   import baud_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [DIV_W-1:0]  div_q,
   output pre_mode_e         mode_q,
   output logic              restart
);
   localparam int NUM_LANES = DIV_W / BYTE_W;
   localparam int CTRL_ADDR = NUM_LANES;

   if (DIV_W % BYTE_W != 0) begin : g_bad_width
      $fatal(1, "divisor width must be a whole number of bytes");
   end
   if (CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $fatal(1, "address width too small for register map");
   end

   logic [BYTE_W-1:0] lane_q [NUM_LANES];

   for (genvar b = 0; b < NUM_LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q[b] <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(b)))
            lane_q[b] <= wr_data;
      end
      assign div_q[b*BYTE_W +: BYTE_W] = lane_q[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= PRE_SLOW;
      else if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)))
         mode_q <= pre_mode_e'(wr_data[CTRL_MODE_BIT]);
   end

   assign restart = wr_en && (wr_addr <= ADDR_W'(CTRL_ADDR));

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
   import baud_pkg::*;
#(
   parameter int PRE_SLOW_DIV = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clear,
   input  pre_mode_e mode,
   output logic      pre_en
);
   localparam int CNT_W = (PRE_SLOW_DIV > 2) ? $clog2(PRE_SLOW_DIV) : 1;

   if (PRE_SLOW_DIV < 2) begin : g_bad_div
      $fatal(1, "slow prescale must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             slow_en;

   if (is_pow2(PRE_SLOW_DIV)) begin : g_pow2
      assign slow_en = &cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cnt_q <= '0;
         else if (clear)   cnt_q <= '0;
         else              cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_cmp
      assign slow_en = (cnt_q == CNT_W'(PRE_SLOW_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt_q <= '0;
         else if (clear)    cnt_q <= '0;
         else if (slow_en)  cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign pre_en = (mode == PRE_FAST) ? 1'b1 : slow_en;

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             pre_en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic             div_zero;
   logic             at_end;

   assign div_zero = (div == '0);
   assign at_end   = (cnt_q == div - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (clear || div_zero) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (pre_en) begin
         if (at_end) begin
            cnt_q <= '0;
            tick  <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
         end
      end else begin
         tick <= 1'b0;
      end
   end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_pkg::*;
#(
   parameter int DIV_W        = 16,
   parameter int BYTE_W       = 8,
   parameter int ADDR_W       = 2,
   parameter int PRE_SLOW_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              tick
);
   logic [DIV_W-1:0] div_q;
   pre_mode_e        mode_q;
   logic             restart;
   logic             pre_en;

   baud_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .div_q   (div_q),
      .mode_q  (mode_q),
      .restart (restart)
   );

   baud_prescaler #(.PRE_SLOW_DIV(PRE_SLOW_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (restart),
      .mode   (mode_q),
      .pre_en (pre_en)
   );

   baud_divider #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (restart),
      .pre_en (pre_en),
      .div    (div_q),
      .tick   (tick)
   );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
   parameter int DIV_W  = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              tick,
   input logic [DIV_W-1:0]  div_q,
   input logic              fast
);
   localparam int CTRL_ADDR = DIV_W / BYTE_W;

   logic wr_hit;
   logic unit_period;
   assign wr_hit      = wr_en && (wr_addr <= ADDR_W'(CTRL_ADDR));
   assign unit_period = fast && (div_q == DIV_W'(1));

   // R4: a zero divisor keeps the strobe low
   assert_div_zero_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q == '0) |=> !tick);

   // R5: a decoded write forces the strobe low in the next cycle
   assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> !tick);

   // R3: strobe is one cycle wide unless the period is one cycle
   assert_single_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !unit_period) |=> !tick);

   // R7: unit period keeps the strobe high while no write restarts it
   assert_unit_period_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && unit_period && !wr_hit) |=> tick);

   // R6: writes to the spare address do not restart or change the divisor
   assert_spare_addr_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr > ADDR_W'(CTRL_ADDR))) |=> $stable(div_q));

endmodule

bind baud_tick_gen baud_tick_gen_chk #(
   .DIV_W  (DIV_W),
   .BYTE_W (BYTE_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .tick    (tick),
   .div_q   (div_q),
   .fast    (mode_q == baud_pkg::PRE_FAST)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tick;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   baud_tick_gen u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .tick    (tick)
   );

   // returns at the falling edge following the write edge (cycle 0)
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Observe n cycles after a write edge; tick expected when k>0 and k % per == 0
   task automatic observe(input int per, input int n, input string req);
      int bad = 0; int first_k = -1; int first_v = 0;
      for (int k = 0; k <= n; k++) begin
         bit exp_t = (per != 0) && (k > 0) && (k % per == 0);
         if (k > 0) begin @(posedge clk); @(negedge clk); end
         if (tick !== exp_t) begin
            if (first_k < 0) begin first_k = k; first_v = int'(tick); end
            bad++;
         end
      end
      if (bad != 0) $display("  mismatch at cycle %0d (period %0d)", first_k, per);
      check(bad == 0, req, first_v, (first_k < 0) ? 0 : int'(!first_v[0]));
   endtask

   task automatic setup(input int pre, input int d);
      wr(2'd0, d[7:0]);
      wr(2'd1, d[15:8]);
      wr(2'd2, (pre == 1) ? 8'h01 : 8'h00);
   endtask

   initial begin
      int p;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
      rst_n = 1'b1;
      observe(0, 30, "R1 silent after reset");
      wr(2'd0, 8'd2);
      observe(8, 30, "R1 default prescale 4");

      // R2/R3/R4/R7 sweep over both prescalers and divisors
      for (int m = 0; m < 2; m++) begin
         p = (m == 0) ? 1 : 4;
         for (int d = 0; d <= 12; d++) begin
            setup(p, d);
            if (d == 0)       observe(0, 40, "R4 zero divisor");
            else if (p*d == 1) observe(1, 20, "R7 unit period");
            else              observe(p*d, 3*p*d + 2, "R2 R3 period sweep");
         end
         setup(p, 300);
         observe(p*300, 2*p*300 + 2, "R2 high byte divisor");
      end

      // R8: writing low byte keeps high byte
      setup(1, 16'h0203);
      wr(2'd0, 8'h05);
      observe(16'h0205, 2*16'h0205 + 2, "R8 byte independence");

      // R5: restart mid-count
      setup(1, 6);
      repeat (4) @(negedge clk);
      wr(2'd0, 8'd6);
      observe(6, 20, "R5 restart mid-count");

      // R6: spare address write is ignored (no restart, no change)
      setup(1, 5);
      begin
         int bad = 0;
         for (int k = 1; k <= 16; k++) begin
            if (k == 3) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'hFF; end
            @(posedge clk); @(negedge clk);
            wr_en = 1'b0;
            if (tick !== (k % 5 == 0)) bad++;
         end
         check(bad == 0, "R6 spare address ignored", bad, 0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule